// File: doc/BRIEF.md
# Cache Tag Store with Compare

This block holds the tag half of a direct-mapped cache directory. Every entry keeps a tag field and three status bits. A processor address index selects one entry. The stored tag comes out combinationally and is compared in the same cycle with the tag presented on the input. The result is a hit flag. A cache controller can use that flag at once to enable the data RAM, with no clock of delay.

Tag writes and status writes are synchronous, and each has its own enable. An active-low clear input, sampled on a rising edge, wipes the status bits of every entry in that single cycle. This invalidates the whole directory without walking it.

A mode input sets the role of the status bits:

- In dedicated mode, the bits mean valid, dirty and write-through, and the valid bit qualifies the hit.
- In generic mode, they are three free user bits that never affect the hit.

Two chip selects must both be high for any access, which allows several stores to share the index bus for depth expansion. The block also forms a transfer-acknowledge output from the hit, the status bits, the processor read/write direction, an external acknowledge input and a force input.

Top module: `cache_tag_store`

## Requirements
- R1: When both selects are high and `tag_we` is high at a rising edge, `tag_in` is stored at entry `idx`. Reading that entry later with `tag_oe` high shows it on `tag_out`.
- R2: When both selects are high and `stat_we` is high at a rising edge, `stat_in` is stored at entry `idx` (bit 0 valid, bit 1 dirty, bit 2 write-through). Reading with `stat_oe` high shows it on `stat_out`.
- R3: `hit` is combinational and requires all tag bits stored at `idx` to equal `tag_in`. A single differing bit clears it.
- R4: With `generic_mode` low, `hit` also requires the valid bit (bit 0) of the addressed entry. An invalid entry never hits.
- R5: With `generic_mode` high, the status bits do not take part in `hit`. A tag-equal entry hits even when its bit 0 is clear.
- R6: `clr_n` low at a rising edge clears the status bits of every entry, whatever the selects are. A status write in the same cycle is overridden, and tag contents are kept.
- R7: With either select low, nothing is written, `hit` is low, and both output-valid flags are low.
- R8: With `tag_oe` low, `tag_out` is zero and `tag_out_vld` is low. With `stat_oe` low, `stat_out` is zero and `stat_out_vld` is low.
- R9: With `ack_oe` high, `ack` is high when any one of these holds:
  - `ack_force` is high;
  - `ack_ext` is high;
  - in dedicated mode, `hit` is high and either `cpu_rd` is high or the entry's write-through bit (bit 2) is clear.
- R10: With `ack_oe` low, `ack` is low whatever its other inputs are.
- R11: A tag write alone leaves the entry's status unchanged, and a status write alone leaves its tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clear act on its rising edge |
| clr_n | input | 1 | Synchronous active-low clear of all status bits |
| sel_a | input | 1 | First chip select, active high |
| sel_b | input | 1 | Second chip select, active high |
| idx | input | INDEX_W | Entry index |
| tag_in | input | TAG_W | Tag to compare or write |
| tag_we | input | 1 | Tag field write enable |
| stat_in | input | 3 | Status to write: bit 0 valid, bit 1 dirty, bit 2 write-through |
| stat_we | input | 1 | Status field write enable |
| tag_oe | input | 1 | Tag read output enable |
| stat_oe | input | 1 | Status read output enable |
| ack_oe | input | 1 | Acknowledge output enable |
| generic_mode | input | 1 | High: status bits are user bits |
| cpu_rd | input | 1 | Processor direction, high for read |
| ack_ext | input | 1 | External acknowledge request |
| ack_force | input | 1 | Forces acknowledge |
| tag_out | output | TAG_W | Stored tag of entry `idx` when enabled, else zero |
| tag_out_vld | output | 1 | `tag_out` carries data |
| stat_out | output | 3 | Stored status of entry `idx` when enabled, else zero |
| stat_out_vld | output | 1 | `stat_out` carries data |
| hit | output | 1 | Qualified tag compare result |
| ack | output | 1 | Transfer acknowledge |

## Verification
The compare is tried with three kinds of tag input:

- the exact stored tag, against a tag differing in one bit, which separates full equality from partial equality;
- matches on entries whose valid bit is clear, in both modes, which separates the dedicated-mode qualification from generic mode;
- write-through lines accessed as reads and as writes, with force and external inputs toggled under both enable states, which tells each term of the acknowledge equation apart.

Random traffic confined to a few entries mixes partial writes, deselected writes and clears landing together with status writes. This shows that the clear covers every entry, overrides a status write in the same cycle, and leaves tags intact.

// File: rtl/cachetag_pkg.sv
package cachetag_pkg;
    typedef struct packed {
        logic wthru;
        logic dirty;
        logic valid;
    } stat_t;
    localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/ct_tag_array.sv
module ct_tag_array #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 12
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   din,
    output logic [TAG_W-1:0]   dout
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [TAG_W-1:0] mem_d [DEPTH];
    logic [TAG_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[idx] = din;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign dout = mem_q[idx];

    // R1
    tag_write_lands_chk: assert property (@(posedge clk)
        wr_en |=> mem_q[$past(idx)] == $past(din));
endmodule

// File: rtl/ct_status_array.sv
module ct_status_array
    import cachetag_pkg::*;
#(
    parameter int INDEX_W = 10
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] idx,
    input  stat_t              din,
    output stat_t              dout
);
    localparam int DEPTH = 1 << INDEX_W;

    stat_t st_d [DEPTH];
    stat_t st_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            st_d[i] = clr_n ? st_q[i] : '0;
        end
        if (clr_n && wr_en) st_d[idx] = din;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q[idx];

    // R6
    clear_all_chk: assert property (@(posedge clk)
        !clr_n |=> dout == '0);

    // R2
    stat_write_lands_chk: assert property (@(posedge clk) disable iff (!clr_n)
        wr_en |=> st_q[$past(idx)] == $past(din));
endmodule

// File: rtl/ct_match_ack.sv
module ct_match_ack
    import cachetag_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sel,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  stat_t            stat,
    input  logic             generic_mode,
    input  logic             cpu_rd,
    input  logic             ack_ext,
    input  logic             ack_force,
    input  logic             ack_oe,
    output logic             hit,
    output logic             ack
);
    logic [TAG_W-1:0] eq_bits;

    genvar g;
    generate
        for (g = 0; g < TAG_W; g++) begin : g_cmp
            assign eq_bits[g] = ~(stored_tag[g] ^ probe_tag[g]);
        end
    endgenerate

    logic tag_eq;
    logic hit_term;

    always_comb begin
        tag_eq   = &eq_bits;
        hit      = sel && tag_eq && (generic_mode || stat.valid);
        hit_term = !generic_mode && hit && (cpu_rd || !stat.wthru);
        ack      = ack_oe && (ack_force || ack_ext || hit_term);
    end

    // R7
    desel_no_hit_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !sel |-> !hit);

    // R4
    invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (hit && !generic_mode) |-> stat.valid);

    // R10
    ack_gated_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !ack_oe |-> !ack);

    // R9
    ack_force_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ack_oe && ack_force) |-> ack);
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cachetag_pkg::*;
#(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 12
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               sel_a,
    input  logic               sel_b,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   tag_in,
    input  logic               tag_we,
    input  logic [2:0]         stat_in,
    input  logic               stat_we,
    input  logic               tag_oe,
    input  logic               stat_oe,
    input  logic               ack_oe,
    input  logic               generic_mode,
    input  logic               cpu_rd,
    input  logic               ack_ext,
    input  logic               ack_force,
    output logic [TAG_W-1:0]   tag_out,
    output logic               tag_out_vld,
    output logic [2:0]         stat_out,
    output logic               stat_out_vld,
    output logic               hit,
    output logic               ack
);
    logic             sel;
    logic [TAG_W-1:0] rd_tag;
    stat_t            rd_stat;

    assign sel = sel_a & sel_b;

    ct_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk  (clk),
        .wr_en(sel & tag_we),
        .idx  (idx),
        .din  (tag_in),
        .dout (rd_tag)
    );

    ct_status_array #(.INDEX_W(INDEX_W)) u_stat (
        .clk  (clk),
        .clr_n(clr_n),
        .wr_en(sel & stat_we),
        .idx  (idx),
        .din  (stat_t'(stat_in)),
        .dout (rd_stat)
    );

    ct_match_ack #(.TAG_W(TAG_W)) u_cmp (
        .clk         (clk),
        .clr_n       (clr_n),
        .sel         (sel),
        .stored_tag  (rd_tag),
        .probe_tag   (tag_in),
        .stat        (rd_stat),
        .generic_mode(generic_mode),
        .cpu_rd      (cpu_rd),
        .ack_ext     (ack_ext),
        .ack_force   (ack_force),
        .ack_oe      (ack_oe),
        .hit         (hit),
        .ack         (ack)
    );

    always_comb begin
        tag_out_vld  = sel && tag_oe;
        stat_out_vld = sel && stat_oe;
        tag_out      = tag_out_vld ? rd_tag : '0;
        stat_out     = stat_out_vld ? rd_stat : '0;
    end

    // R8
    tag_oe_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !tag_out_vld |-> tag_out == '0);

    // R11
    tag_only_keeps_stat_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel && tag_we && !stat_we) |=> $stable(rd_stat) || ($past(idx) != idx));
endmodule

// File: tb/cache_tag_store_tb.sv
module cache_tag_store_tb;
    localparam int IW = 10;
    localparam int TW = 12;
    localparam int DEPTH = 1 << IW;

    logic clk = 0;
    always #5 clk = ~clk;

    logic clr_n, sel_a, sel_b, tag_we, stat_we, tag_oe, stat_oe, ack_oe;
    logic generic_mode, cpu_rd, ack_ext, ack_force;
    logic [IW-1:0] idx;
    logic [TW-1:0] tag_in;
    logic [2:0] stat_in;
    logic [TW-1:0] tag_out;
    logic [2:0] stat_out;
    logic tag_out_vld, stat_out_vld, hit, ack;

    cache_tag_store #(.INDEX_W(IW), .TAG_W(TW)) u_dut (
        .clk(clk), .clr_n(clr_n), .sel_a(sel_a), .sel_b(sel_b), .idx(idx),
        .tag_in(tag_in), .tag_we(tag_we), .stat_in(stat_in), .stat_we(stat_we),
        .tag_oe(tag_oe), .stat_oe(stat_oe), .ack_oe(ack_oe),
        .generic_mode(generic_mode), .cpu_rd(cpu_rd), .ack_ext(ack_ext),
        .ack_force(ack_force), .tag_out(tag_out), .tag_out_vld(tag_out_vld),
        .stat_out(stat_out), .stat_out_vld(stat_out_vld), .hit(hit), .ack(ack)
    );

    logic [TW-1:0] m_tag [DEPTH];
    logic [2:0]    m_stat [DEPTH];
    int n_run = 0;
    int n_fail = 0;
    bit chk_en = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit();
        return sel_a && sel_b && (m_tag[idx] == tag_in) && (generic_mode || m_stat[idx][0]);
    endfunction

    function automatic bit exp_ack();
        bit h = exp_hit();
        return ack_oe && (ack_force || ack_ext ||
               (!generic_mode && h && (cpu_rd || !m_stat[idx][2])));
    endfunction

    task automatic go(input string lbl);
        bit s;
        @(negedge clk);
        #1;
        s = sel_a && sel_b;
        if (chk_en) begin
            chk(tag_out == ((s && tag_oe) ? m_tag[idx] : '0), {lbl, " R1 R8 tag_out"},
                int'(tag_out), int'((s && tag_oe) ? m_tag[idx] : '0));
            chk(tag_out_vld == (s && tag_oe), {lbl, " R7 R8 tag_out_vld"},
                int'(tag_out_vld), int'(s && tag_oe));
            chk(stat_out == ((s && stat_oe) ? m_stat[idx] : 3'b0), {lbl, " R2 R8 stat_out"},
                int'(stat_out), int'((s && stat_oe) ? m_stat[idx] : 3'b0));
            chk(stat_out_vld == (s && stat_oe), {lbl, " R7 R8 stat_out_vld"},
                int'(stat_out_vld), int'(s && stat_oe));
            chk(hit == exp_hit(), {lbl, " R3 R4 R5 R7 hit"}, int'(hit), int'(exp_hit()));
            chk(ack == exp_ack(), {lbl, " R9 R10 ack"}, int'(ack), int'(exp_ack()));
        end
        @(posedge clk);
        if (!clr_n) begin
            for (int i = 0; i < DEPTH; i++) m_stat[i] = 3'b0;
        end else if (s && stat_we) m_stat[idx] = stat_in;
        if (s && tag_we) m_tag[idx] = tag_in;
        #1;
    endtask

    task automatic idle();
        clr_n = 1; sel_a = 1; sel_b = 1; tag_we = 0; stat_we = 0;
        tag_oe = 1; stat_oe = 1; ack_oe = 1; generic_mode = 0;
        cpu_rd = 1; ack_ext = 0; ack_force = 0; stat_in = 0;
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        idle(); idx = 0; tag_in = 0;
        clr_n = 0;
        go("init");
        clr_n = 1; idx = 3; tag_in = 0;
        @(negedge clk); #1;
        // R6 reset state: all status cleared, no hit in dedicated mode
        chk(stat_out == 3'b0, "R6 reset stat_out", int'(stat_out), 0);
        chk(hit == 1'b0, "R6 R4 reset hit", int'(hit), 0);
        @(posedge clk); #1;
        tag_oe = 0; stat_oe = 0; tag_we = 1;
        for (int i = 0; i < DEPTH; i++) begin
            idx = IW'(i); tag_in = TW'(i * 37);
            go("fill");
        end
        idle();
        chk_en = 1;

        // R1 R2 write tag and valid status
        idx = 5; tag_in = 12'hABC; tag_we = 1; stat_we = 1; stat_in = 3'b001; go("R1");
        tag_we = 0; stat_we = 0; go("R3 exact");
        tag_in = 12'hABD; go("R3 one-bit diff");
        // R4 R5 invalid entry
        tag_in = 12'hABC; stat_we = 1; stat_in = 3'b110; go("R2");
        stat_we = 0; go("R4 invalid");
        generic_mode = 1; go("R5 generic");
        generic_mode = 0;
        // R11 tag-only write keeps status
        tag_in = 12'h123; tag_we = 1; go("R11 tag write");
        tag_we = 0; go("R11 readback");
        // R7 deselected write
        sel_b = 0; tag_we = 1; stat_we = 1; tag_in = 12'hFFF; stat_in = 3'b111; go("R7 desel");
        sel_b = 1; tag_we = 0; stat_we = 0; tag_in = 12'h123; go("R7 after");
        // R9 write-through line: write vs read
        stat_we = 1; stat_in = 3'b101; go("R9 set wt");
        stat_we = 0; cpu_rd = 0; go("R9 wt write");
        cpu_rd = 1; go("R9 wt read");
        // R10 gating
        ack_oe = 0; ack_force = 1; ack_ext = 1; go("R10 gated");
        ack_oe = 1; ack_ext = 0; sel_a = 0; go("R9 force");
        ack_force = 0; ack_ext = 1; go("R9 ext");
        idle();
        // R6 clear with simultaneous status write, tags kept
        tag_in = 12'h123; clr_n = 0; stat_we = 1; stat_in = 3'b111; go("R6 clear+write");
        clr_n = 1; stat_we = 0; go("R6 after");
        idx = 6; tag_in = TW'(6 * 37); go("R6 other entry");

        for (int n = 0; n < 3000; n++) begin
            idx = IW'($urandom % 16);
            sel_a = ($urandom % 8) != 0;
            sel_b = ($urandom % 8) != 0;
            clr_n = ($urandom % 64) != 0;
            tag_we = ($urandom % 4) == 0;
            stat_we = ($urandom % 3) == 0;
            stat_in = 3'($urandom);
            tag_oe = ($urandom % 4) != 0;
            stat_oe = ($urandom % 4) != 0;
            ack_oe = ($urandom % 4) != 0;
            generic_mode = ($urandom % 4) == 0;
            cpu_rd = 1'($urandom);
            ack_ext = ($urandom % 8) == 0;
            ack_force = ($urandom % 8) == 0;
            tag_in = ($urandom % 2) ? m_tag[idx] : TW'($urandom);
            go("rand");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule